// File: doc/BRIEF.md
# Dual-Latch Parallel DAC Write Sequencer

This block turns single-beat write requests from an on-chip host into correctly timed bus cycles for a dual 8-bit parallel DAC. The host offers an address bit and a data byte under a valid/ready handshake. The sequencer drives the converter's active-low chip select, active-low write strobe, channel-select line and data bus. Every timing minimum on that port is a parameter in nanoseconds. Each one is rounded up to whole cycles of a clock whose period is also a parameter, so the same RTL meets the port timing at any system clock rate.

One write runs through five phases. First the channel select and the data byte are driven. Then chip select falls, and one or more cycles later the write strobe falls. The write strobe stays low for the pulse width. Chip select and write strobe then rise on the same edge, and the select and data are held for the hold time before the host is offered the port again. The lowest host address bit picks the channel: 0 selects latch A and 1 selects latch B.

The block also contains a cycle-level model of the converter's two input latches, so that neighbouring logic and checks can see what the converter holds. A latch follows the bus while chip select and write strobe are both low and the channel matches, and it holds its value otherwise.

Top module: `dacwr_seq`

## Requirements
- R1: While synchronous reset is applied and right after it, chip select and write strobe are high, channel select and data bus are 0, both model latches read 0 and reqReady is 1.
- R2: A request with reqAddr=0 drives dacChSel low and updates only latchA. A request with reqAddr=1 drives dacChSel high and updates only latchB. The other latch keeps its value.
- R3: Chip select is low for at least ceil(CS_SETUP_NS/CLK_PERIOD_NS) cycles before the write strobe rises. It falls at least one cycle before the write strobe falls and rises on the same edge as the write strobe. The write strobe is never low while chip select is high.
- R4: dacChSel and dacData are unchanged for at least ceil(SEL_SETUP_NS/CLK_PERIOD_NS) and ceil(DATA_SETUP_NS/CLK_PERIOD_NS) cycles respectively before the write strobe rises, and they stay unchanged while chip select is low.
- R5: The write strobe stays low for at least ceil(WR_PULSE_NS/CLK_PERIOD_NS) cycles.
- R6: After the write strobe rises, dacChSel and dacData stay unchanged for at least max(1, ceil(SEL_HOLD_NS/CLK_PERIOD_NS), ceil(DATA_HOLD_NS/CLK_PERIOD_NS)) cycles.
- R7: After a request is accepted, reqReady stays low for exactly max(Wp+2, Cs+1, Ss, Ds) + max(1, Sh, Dh) cycles. The terms are the rounded cycle counts for pulse width, chip-select setup, select setup, data setup, select hold and data hold. Host input changes during that time do not affect the write in progress, and a request held valid is accepted on the first cycle that reqReady is high.
- R8: A model latch follows the bus (visible one cycle later) while chip select and write strobe are both low and the channel matches, and it holds the last value once either strobe goes high.
- R9: While reqValid is low, chip select and write strobe stay high and both latches hold, whatever reqAddr and reqData do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request valid |
| reqAddr | input | 1 | Lowest host address bit: 0 selects channel A, 1 selects channel B |
| reqData | input | DATA_W | Host write data |
| reqReady | output | 1 | Sequencer is idle and accepts a request |
| dacCsN | output | 1 | Converter chip select, active low |
| dacWrN | output | 1 | Converter write strobe, active low |
| dacChSel | output | 1 | Channel select: low for latch A, high for latch B |
| dacData | output | DATA_W | Converter data bus |
| latchA | output | DATA_W | Model of converter latch A |
| latchB | output | DATA_W | Model of converter latch B |

## Verification
The bench measures every strobe edge in clock cycles against the rounded minimums. A design with a counter that is one cycle short would shorten the write pulse or a setup window, and the bench reports that as a timing failure rather than a data error. A request held valid across a busy period is the back-to-back corner: accepting it early would overwrite the bus inside the hold window and corrupt the first channel's latch. Toggling host inputs while idle or busy catches a sequencer that lets a write strobe through without a request or that re-samples data during the write. Transparency is checked while the strobe is still low, so a model that captures only at the rising edge is caught.

// File: rtl/dacwr_pkg.sv
`timescale 1ns/1ps
package dacwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRIVE = 3'd1,
    ST_CSLOW = 3'd2,
    ST_WRLOW = 3'd3,
    ST_HOLD  = 3'd4
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic csLow;
    logic wrLow;
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacwr_ctrl.sv
`timescale 1ns/1ps
module dacwr_ctrl
  import dacwr_pkg::*;
#(
  parameter int DRIVE_CYC = 1,
  parameter int CSLOW_CYC = 1,
  parameter int WRLOW_CYC = 10,
  parameter int HOLD_CYC  = 2,
  parameter int CNT_W     = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  output logic    reqReady,
  output strobe_t strobes
);

  seqState_t state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state <= ST_DRIVE;
            cnt   <= CNT_W'(DRIVE_CYC - 1);
          end
        end
        ST_DRIVE: begin
          if (cnt == '0) begin
            state <= ST_CSLOW;
            cnt   <= CNT_W'(CSLOW_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CSLOW: begin
          if (cnt == '0) begin
            state <= ST_WRLOW;
            cnt   <= CNT_W'(WRLOW_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRLOW: begin
          if (cnt == '0) begin
            state <= ST_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    reqReady        = (state == ST_IDLE);
    strobes.capture = (state == ST_IDLE) && reqValid;
    strobes.csLow   = (state == ST_CSLOW) || (state == ST_WRLOW);
    strobes.wrLow   = (state == ST_WRLOW);
  end

endmodule

// File: rtl/dacwr_datapath.sv
`timescale 1ns/1ps
module dacwr_datapath
  import dacwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic              reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              dacCsN,
  output logic              dacWrN,
  output logic              dacChSel,
  output logic [DATA_W-1:0] dacData
);

  logic              chSelQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      chSelQ <= 1'b0;
      dataQ  <= '0;
    end else if (strobes.capture) begin
      chSelQ <= reqAddr;
      dataQ  <= reqData;
    end
  end

  assign dacChSel = chSelQ;
  assign dacData  = dataQ;
  assign dacCsN   = ~strobes.csLow;
  assign dacWrN   = ~strobes.wrLow;

endmodule

// File: rtl/dacwr_latch_model.sv
`timescale 1ns/1ps
module dacwr_latch_model #(
  parameter int DATA_W = 8,
  parameter int N_CH   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic              chSel,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] latchA,
  output logic [DATA_W-1:0] latchB
);

  logic [DATA_W-1:0] latchQ [N_CH];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        latchQ[ch] <= '0;
      end else if (!csN && !wrN && (int'(chSel) == ch)) begin
        latchQ[ch] <= busData;
      end
    end
  end

  assign latchA = latchQ[0];
  assign latchB = latchQ[1];

endmodule

// File: rtl/dacwr_seq.sv
`timescale 1ns/1ps
module dacwr_seq
  import dacwr_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int CS_SETUP_NS   = 50,
  parameter int SEL_SETUP_NS  = 50,
  parameter int SEL_HOLD_NS   = 10,
  parameter int DATA_SETUP_NS = 25,
  parameter int DATA_HOLD_NS  = 10,
  parameter int WR_PULSE_NS   = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              dacCsN,
  output logic              dacWrN,
  output logic              dacChSel,
  output logic [DATA_W-1:0] dacData,
  output logic [DATA_W-1:0] latchA,
  output logic [DATA_W-1:0] latchB
);

  localparam int CS_CYC  = ceilDiv(CS_SETUP_NS, CLK_PERIOD_NS);
  localparam int SS_CYC  = ceilDiv(SEL_SETUP_NS, CLK_PERIOD_NS);
  localparam int SH_CYC  = ceilDiv(SEL_HOLD_NS, CLK_PERIOD_NS);
  localparam int DS_CYC  = ceilDiv(DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int DH_CYC  = ceilDiv(DATA_HOLD_NS, CLK_PERIOD_NS);
  localparam int WR_CYC  = maxOf(1, ceilDiv(WR_PULSE_NS, CLK_PERIOD_NS));
  // chip select leads the write strobe by at least one cycle
  localparam int CSL_CYC = maxOf(1, CS_CYC - WR_CYC);
  localparam int DRV_CYC = maxOf(1, maxOf(SS_CYC, DS_CYC) - CSL_CYC - WR_CYC);
  localparam int HLD_CYC = maxOf(1, maxOf(SH_CYC, DH_CYC));
  localparam int MAX_PH  = maxOf(maxOf(DRV_CYC, CSL_CYC), maxOf(WR_CYC, HLD_CYC));
  localparam int CNT_W   = maxOf(1, $clog2(MAX_PH + 1));

  strobe_t strobes;

  dacwr_ctrl #(
    .DRIVE_CYC(DRV_CYC),
    .CSLOW_CYC(CSL_CYC),
    .WRLOW_CYC(WR_CYC),
    .HOLD_CYC (HLD_CYC),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  dacwr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .dacCsN  (dacCsN),
    .dacWrN  (dacWrN),
    .dacChSel(dacChSel),
    .dacData (dacData)
  );

  dacwr_latch_model #(.DATA_W(DATA_W), .N_CH(2)) u_model (
    .clk    (clk),
    .rst    (rst),
    .csN    (dacCsN),
    .wrN    (dacWrN),
    .chSel  (dacChSel),
    .busData(dacData),
    .latchA (latchA),
    .latchB (latchB)
  );

endmodule

// File: rtl/dacwr_seq_chk.sv
`timescale 1ns/1ps
module dacwr_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              dacCsN,
  input logic              dacWrN,
  input logic              dacChSel,
  input logic [DATA_W-1:0] dacData,
  input logic [DATA_W-1:0] latchA,
  input logic [DATA_W-1:0] latchB
);

  // R3
  wr_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !dacWrN |-> !dacCsN);

  // R3
  cs_rise_with_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dacCsN) |-> $rose(dacWrN));

  // R4
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !dacCsN |-> ($stable(dacChSel) && $stable(dacData)));

  // R7
  busy_during_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !dacCsN |-> !reqReady);

  // R2
  other_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dacChSel |=> $stable(latchB));

  // R8
  cs_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dacCsN |=> ($stable(latchA) && $stable(latchB)));

endmodule

bind dacwr_seq dacwr_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reqReady(reqReady),
  .dacCsN  (dacCsN),
  .dacWrN  (dacWrN),
  .dacChSel(dacChSel),
  .dacData (dacData),
  .latchA  (latchA),
  .latchB  (latchB)
);

// File: tb/dacwr_seq_tb.sv
`timescale 1ns/1ps
module dacwr_seq_tb;

  localparam int DW    = 8;
  localparam int TCLK  = 5;
  localparam int CS_NS = 50, SS_NS = 50, SH_NS = 10, DS_NS = 25, DH_NS = 10, WP_NS = 50;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CS_C = cdiv(CS_NS, TCLK);
  localparam int SS_C = cdiv(SS_NS, TCLK);
  localparam int DS_C = cdiv(DS_NS, TCLK);
  localparam int WP_C = cdiv(WP_NS, TCLK);
  localparam int HD_C = mx(1, mx(cdiv(SH_NS, TCLK), cdiv(DH_NS, TCLK)));
  localparam int BUSY = mx(mx(WP_C + 2, CS_C + 1), mx(SS_C, DS_C)) + HD_C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqAddr = 1'b0;
  logic [DW-1:0] reqData = '0;
  logic          reqReady, dacCsN, dacWrN, dacChSel;
  logic [DW-1:0] dacData, latchA, latchB;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] mA = '0, mB = '0;

  always #2.5 clk = ~clk;

  dacwr_seq #(
    .DATA_W(DW), .CLK_PERIOD_NS(TCLK), .CS_SETUP_NS(CS_NS), .SEL_SETUP_NS(SS_NS),
    .SEL_HOLD_NS(SH_NS), .DATA_SETUP_NS(DS_NS), .DATA_HOLD_NS(DH_NS), .WR_PULSE_NS(WP_NS)
  ) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData),
    .reqReady(reqReady), .dacCsN(dacCsN), .dacWrN(dacWrN), .dacChSel(dacChSel),
    .dacData(dacData), .latchA(latchA), .latchB(latchB)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Port timing monitor, sampled on the falling edge
  int  csRun, wrRun, selRun, datRun, sinceRise;
  bit  seenRise;
  logic prevWrN, prevCsN, prevSel;
  logic [DW-1:0] prevDat;

  always @(negedge clk) begin
    if (rst) begin
      csRun = 0; wrRun = 0; selRun = 0; datRun = 0; sinceRise = 0; seenRise = 0;
      prevWrN = 1'b1; prevCsN = 1'b1; prevSel = dacChSel; prevDat = dacData;
    end else begin
      if (dacWrN && !prevWrN) begin
        check(csRun >= CS_C, "R3 cs setup", csRun, CS_C);
        check(dacCsN == 1'b1, "R3 cs rises with wr", int'(dacCsN), 1);
        check(selRun >= SS_C, "R4 select setup", selRun, SS_C);
        check(datRun >= DS_C, "R4 data setup", datRun, DS_C);
        check(wrRun >= WP_C, "R5 wr pulse", wrRun, WP_C);
        seenRise = 1; sinceRise = 0;
      end
      if (!dacWrN && prevWrN)
        check(prevCsN == 1'b0, "R3 cs before wr", int'(prevCsN), 0);
      if (seenRise) sinceRise++;
      if ((dacChSel != prevSel || dacData != prevDat) && seenRise)
        check(sinceRise - 1 >= HD_C, "R6 hold", sinceRise - 1, HD_C);
      csRun  = dacCsN ? 0 : csRun + 1;
      wrRun  = dacWrN ? 0 : wrRun + 1;
      selRun = (dacChSel != prevSel) ? 1 : selRun + 1;
      datRun = (dacData != prevDat) ? 1 : datRun + 1;
      prevWrN = dacWrN; prevCsN = dacCsN; prevSel = dacChSel; prevDat = dacData;
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dacCsN && dacWrN, "R1 strobes high in reset", int'({dacCsN, dacWrN}), 3);
    rst = 1'b0;
    @(negedge clk);
    check(dacCsN && dacWrN && reqReady, "R1 idle after reset", int'({dacCsN, dacWrN, reqReady}), 7);
    check(latchA == 0 && latchB == 0, "R1 latches zero", int'({latchA, latchB}), 0);
    check(dacChSel == 0 && dacData == 0, "R1 bus zero", int'({dacChSel, dacData}), 0);
  endtask

  // Count busy samples after acceptance; check transparency and select on the way
  task automatic wait_busy(input logic a, input logic [DW-1:0] d, output int busy);
    int lowSeen = 0;
    busy = 0;
    check(dacChSel == a, "R2 channel select", int'(dacChSel), int'(a));
    while (!reqReady && busy < 1000) begin
      busy++;
      if (!dacWrN) begin
        lowSeen++;
        if (lowSeen == 2)
          check((a ? latchB : latchA) == d, "R8 transparent while low",
                int'(a ? latchB : latchA), int'(d));
      end
      @(negedge clk);
    end
  endtask

  task automatic t_write(input logic a, input logic [DW-1:0] d);
    int busy;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqData = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqData = ~d;  // ignored while busy (R7)
    wait_busy(a, d, busy);
    check(busy == BUSY, "R7 busy length", busy, BUSY);
    if (a) mB = d; else mA = d;
    check(latchA == mA, "R2 latch A", int'(latchA), int'(mA));
    check(latchB == mB, "R2 latch B", int'(latchB), int'(mB));
  endtask

  task automatic t_back_to_back(input logic [DW-1:0] d1, input logic [DW-1:0] d2);
    int busy1, busy2, gap;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 1'b0; reqData = d1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqAddr = 1'b1; reqData = d2;  // second request held valid
    wait_busy(1'b0, d1, busy1);
    check(busy1 == BUSY, "R7 first busy length", busy1, BUSY);
    mA = d1;
    check(latchA == mA, "R7 first write not disturbed", int'(latchA), int'(mA));
    gap = 0;
    while (reqReady && gap < 10) begin gap++; @(negedge clk); end
    check(gap == 1, "R7 accept on first ready cycle", gap, 1);
    reqValid = 1'b0;
    wait_busy(1'b1, d2, busy2);
    check(busy2 == BUSY, "R7 second busy length", busy2, BUSY);
    mB = d2;
    check(latchA == mA && latchB == mB, "R2 both latches after pair",
          int'({latchA, latchB}), int'({mA, mB}));
  endtask

  task automatic t_idle_ignore();
    bit strobesOk = 1;
    reqValid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      reqAddr = i[0]; reqData = DW'(i * 37);
      if (!(dacCsN && dacWrN && reqReady)) strobesOk = 0;
    end
    @(negedge clk);
    check(strobesOk, "R9 strobes idle without valid", int'(strobesOk), 1);
    check(latchA == mA && latchB == mB, "R9 latches hold while idle",
          int'({latchA, latchB}), int'({mA, mB}));
  endtask

  initial begin : watchdog
    #(200000 * TCLK);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_write(1'b0, 8'hA5);
    t_write(1'b1, 8'h5A);
    t_write(1'b0, 8'hFF);
    t_write(1'b1, 8'h00);
    t_idle_ignore();
    t_back_to_back(8'h3C, 8'hC3);
    t_write(1'b1, 8'h81);
    t_idle_ignore();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule